// File: doc/BRIEF.md
# Edge-Detecting Interrupt Status Field

This block holds a status field of `WIDTH` bits that records activity on a hardware event vector. It is meant to sit behind a register interface, which reads `field_q` and issues write-one-to-clear strobes. The summary `irq` goes to an interrupt controller.

A 3-bit `cap_mode` input picks one of eight capture rules. The rules differ in two ways: whether a bit is captured from the input level or from an edge of the input, and whether a captured bit stays set until software clears it. Edges are found by comparing the current input with a copy registered one cycle earlier. The field updates on every clock edge.

A clear strobe removes the selected bits. In the same cycle it wins over any capture for those bits. All pins are plain control and status signals with no handshake: the input vector is sampled on every clock edge, and the field is always valid.

Top module: `irqf_status_field`

## Requirements
- R1: While reset is asserted, and on the first sample after it, `field_q` is zero and `irq` is low.
- R2: With `cap_mode` = 0 (level), each cycle the field loads the input vector present at the previous clock edge.
- R3: With `cap_mode` = 1 (accumulate), the next field is the stored field OR the input, so bits stay set until cleared.
- R4: With `cap_mode` = 2 (rise, held), the next field is the stored field OR (NOT previous input AND current input).
- R5: With `cap_mode` = 3 (fall, held), the next field is the stored field OR (previous input AND NOT current input).
- R6: With `cap_mode` = 4 (any edge, held), the next field is the stored field OR (previous input XOR current input).
- R7: With `cap_mode` = 5, 6 or 7 (rise, fall or any edge, pulsed), the field loads only the bare edge term, without the stored value, so each edge shows for exactly one cycle.
- R8: When `clr_stb` is high, every bit set in `clr_bits` is zero in the next field, whatever the capture rule would load. Bits not selected follow their rule. When `clr_stb` is low, `clr_bits` has no effect.
- R9: `irq` is high exactly when at least one bit of `field_q` is set.
- R10: The previous-input copy resets to zero. In an edge mode, an input bit that is high at the first clock edge after reset counts as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cap_mode | input | 3 | Capture rule selection, codes 0 to 7 as listed in R2 to R7 |
| hw_in | input | WIDTH | Hardware event vector |
| clr_stb | input | 1 | Write-one-to-clear strobe |
| clr_bits | input | WIDTH | Mask of the bits to clear, used only while `clr_stb` is high |
| field_q | output | WIDTH | Stored field value |
| irq | output | 1 | OR of all field bits |

## Verification
The hardest case to reach is a clear and a fresh capture on the same bit in the same cycle. The clear must win for that cycle, and the bit must come back on the next edge if the input is still active. A second hard case is the first edge after reset, where the zeroed previous-input copy turns an input that is already high into a rising edge.

The stimulus table reaches the first case by holding inputs high while strobing clears in level, accumulate and edge modes. It also switches modes partway through the run, so that stored bits and the previous-input copy carry over between rules. A directed test holds the input high through reset to reach the second case.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
  typedef enum logic [2:0] {
    CAP_LEVEL     = 3'd0,
    CAP_ACCUM     = 3'd1,
    CAP_RISE_HOLD = 3'd2,
    CAP_FALL_HOLD = 3'd3,
    CAP_ANY_HOLD  = 3'd4,
    CAP_RISE_PULS = 3'd5,
    CAP_FALL_PULS = 3'd6,
    CAP_ANY_PULS  = 3'd7
  } cap_mode_e;
endpackage

// File: rtl/irqf_input_delay.sv
module irqf_input_delay #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] cur_in,
  output logic [WIDTH-1:0] prev_q
);
  // One-cycle copy of the event vector, used for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur_in;
  end
endmodule

// File: rtl/irqf_capture_logic.sv
module irqf_capture_logic
  import irqf_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  cap_mode_e        mode,
  input  logic [WIDTH-1:0] stored,
  input  logic [WIDTH-1:0] prev_in,
  input  logic [WIDTH-1:0] cur_in,
  output logic [WIDTH-1:0] cand
);
  logic [WIDTH-1:0] rise_t, fall_t, any_t;

  // Edge terms are computed bit by bit
  for (genvar b = 0; b < WIDTH; b++) begin : g_edge
    assign rise_t[b] = ~prev_in[b] &  cur_in[b];
    assign fall_t[b] =  prev_in[b] & ~cur_in[b];
    assign any_t[b]  =  prev_in[b] ^  cur_in[b];
  end

  always_comb begin
    unique case (mode)
      CAP_LEVEL:     cand = cur_in;
      CAP_ACCUM:     cand = stored | cur_in;
      CAP_RISE_HOLD: cand = stored | rise_t;
      CAP_FALL_HOLD: cand = stored | fall_t;
      CAP_ANY_HOLD:  cand = stored | any_t;
      CAP_RISE_PULS: cand = rise_t;
      CAP_FALL_PULS: cand = fall_t;
      CAP_ANY_PULS:  cand = any_t;
      default:       cand = stored;
    endcase
  end
endmodule

// File: rtl/irqf_field_store.sv
module irqf_field_store #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] cand,
  input  logic             clr_stb,
  input  logic [WIDTH-1:0] clr_bits,
  output logic [WIDTH-1:0] field_q,
  output logic             irq
);
  logic [WIDTH-1:0] kill;
  logic [WIDTH-1:0] nxt;

  // The clear mask takes effect only while the strobe is high
  assign kill = clr_stb ? clr_bits : '0;
  // A clear overrides the capture on the bits it selects
  assign nxt  = cand & ~kill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) field_q <= '0;
    else        field_q <= nxt;
  end

  assign irq = |field_q;
endmodule

// File: rtl/irqf_status_field.sv
module irqf_status_field
  import irqf_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cap_mode,
  input  logic [WIDTH-1:0] hw_in,
  input  logic             clr_stb,
  input  logic [WIDTH-1:0] clr_bits,
  output logic [WIDTH-1:0] field_q,
  output logic             irq
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] cand;
  cap_mode_e        mode_e;

  assign mode_e = cap_mode_e'(cap_mode);

  irqf_input_delay #(.WIDTH(WIDTH)) u_dly (
    .clk    (clk),
    .rst_n  (rst_n),
    .cur_in (hw_in),
    .prev_q (prev_q)
  );

  irqf_capture_logic #(.WIDTH(WIDTH)) u_cap (
    .mode    (mode_e),
    .stored  (field_q),
    .prev_in (prev_q),
    .cur_in  (hw_in),
    .cand    (cand)
  );

  irqf_field_store #(.WIDTH(WIDTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .cand     (cand),
    .clr_stb  (clr_stb),
    .clr_bits (clr_bits),
    .field_q  (field_q),
    .irq      (irq)
  );
endmodule

// File: rtl/irqf_status_field_chk.sv
module irqf_status_field_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       cap_mode,
  input logic [WIDTH-1:0] hw_in,
  input logic             clr_stb,
  input logic [WIDTH-1:0] clr_bits,
  input logic [WIDTH-1:0] field_q,
  input logic             irq
);
  AST_LEVEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_mode == 3'd0 && !clr_stb) |=> (field_q == $past(hw_in))); // R2

  AST_ACCUM_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_mode == 3'd1 && !clr_stb) |=> ((field_q & $past(hw_in)) == $past(hw_in))); // R3

  AST_HELD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_mode >= 3'd2 && cap_mode <= 3'd4 && !clr_stb)
      |=> (($past(field_q) & ~field_q) == '0)); // R6

  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_mode == 3'd5 && $past(cap_mode) == 3'd5) |-> ((field_q & $past(field_q)) == '0)); // R7

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((field_q & $past(clr_bits)) == '0)); // R8

  AST_IRQ_LOW_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (field_q == '0) |-> !irq); // R9
endmodule

bind irqf_status_field irqf_status_field_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cap_mode (cap_mode),
  .hw_in    (hw_in),
  .clr_stb  (clr_stb),
  .clr_bits (clr_bits),
  .field_q  (field_q),
  .irq      (irq)
);

// File: tb/irqf_status_field_tb.sv
module irqf_status_field_tb_top;
  localparam int W  = 4;
  localparam int NV = 28;

  // Each entry is {mode[11:9], hw[8:5], clr_stb[4], clr_bits[3:0]}
  localparam logic [11:0] VEC [NV] = '{
    {3'd0, 4'b1010, 1'b0, 4'b0000},
    {3'd0, 4'b0101, 1'b0, 4'b0000},
    {3'd0, 4'b1111, 1'b1, 4'b0011},
    {3'd0, 4'b1111, 1'b0, 4'b0000},
    {3'd1, 4'b0001, 1'b0, 4'b0000},
    {3'd1, 4'b0100, 1'b0, 4'b0000},
    {3'd1, 4'b0100, 1'b1, 4'b0100},
    {3'd1, 4'b0000, 1'b1, 4'b1111},
    {3'd2, 4'b0011, 1'b0, 4'b0000},
    {3'd2, 4'b0000, 1'b0, 4'b0000},
    {3'd2, 4'b1000, 1'b1, 4'b1000},
    {3'd2, 4'b0000, 1'b1, 4'b1111},
    {3'd3, 4'b1100, 1'b0, 4'b0000},
    {3'd3, 4'b0100, 1'b0, 4'b0000},
    {3'd3, 4'b0000, 1'b1, 4'b1000},
    {3'd3, 4'b0000, 1'b1, 4'b1111},
    {3'd4, 4'b0001, 1'b0, 4'b0000},
    {3'd4, 4'b0000, 1'b0, 4'b0000},
    {3'd4, 4'b0110, 1'b1, 4'b1111},
    {3'd5, 4'b0000, 1'b0, 4'b0000},
    {3'd5, 4'b1001, 1'b0, 4'b0000},
    {3'd5, 4'b1001, 1'b0, 4'b0000},
    {3'd6, 4'b0001, 1'b0, 4'b0000},
    {3'd6, 4'b0000, 1'b0, 4'b0000},
    {3'd6, 4'b0000, 1'b0, 4'b0000},
    {3'd7, 4'b1010, 1'b0, 4'b0000},
    {3'd7, 4'b0110, 1'b1, 4'b0100},
    {3'd7, 4'b0110, 1'b0, 4'b0000}
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic [2:0]   cap_mode;
  logic [W-1:0] hw_in;
  logic         clr_stb;
  logic [W-1:0] clr_bits;
  logic [W-1:0] field_q;
  logic         irq;

  int total = 0;
  int bad   = 0;
  logic [W-1:0] m_field, m_prev;

  always #5 clk = ~clk;

  irqf_status_field #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cap_mode(cap_mode), .hw_in(hw_in),
    .clr_stb(clr_stb), .clr_bits(clr_bits), .field_q(field_q), .irq(irq)
  );

  function automatic string req_of(input logic [2:0] m);
    case (m)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Reference model of one clock edge, written from the requirements
  task automatic model_step(input logic [2:0] m, input logic [W-1:0] h,
                            input logic c, input logic [W-1:0] cb);
    logic [W-1:0] r, f, a, n;
    r = ~m_prev & h;
    f = m_prev & ~h;
    a = m_prev ^ h;
    case (m)
      3'd0: n = h;
      3'd1: n = m_field | h;
      3'd2: n = m_field | r;
      3'd3: n = m_field | f;
      3'd4: n = m_field | a;
      3'd5: n = r;
      3'd6: n = f;
      default: n = a;
    endcase
    if (c) n = n & ~cb;
    m_field = n;
    m_prev  = h;
  endtask

  task automatic apply(input logic [2:0] m, input logic [W-1:0] h,
                       input logic c, input logic [W-1:0] cb, input string req);
    @(negedge clk);
    cap_mode = m; hw_in = h; clr_stb = c; clr_bits = cb;
    model_step(m, h, c, cb);
    @(posedge clk);
    #1;
    check(req, field_q, m_field);
    check("R9", {{(W-1){1'b0}}, irq}, {{(W-1){1'b0}}, |m_field});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cap_mode = 3'd0; hw_in = '1; clr_stb = 1'b0; clr_bits = '0;
    m_field = '0; m_prev = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", field_q, '0);
    check("R1", {{(W-1){1'b0}}, irq}, '0);
    @(negedge clk);
    hw_in = '0;
    rst_n = 1'b1;

    // Table walk, with the model carried across mode changes
    for (int i = 0; i < NV; i++) begin
      logic [11:0] v;
      string rq;
      v  = VEC[i];
      rq = v[4] ? {req_of(v[11:9]), "/R8"} : req_of(v[11:9]);
      apply(v[11:9], v[8:5], v[4], v[3:0], rq);
    end

    // R10: input held high through reset counts as a rising edge
    @(negedge clk);
    rst_n = 1'b0; cap_mode = 3'd2; hw_in = 4'b1011; clr_stb = 1'b0;
    m_field = '0; m_prev = '0;
    @(posedge clk);
    #1;
    check("R1", field_q, '0);
    @(negedge clk);
    rst_n = 1'b1;
    apply(3'd2, 4'b1011, 1'b0, 4'b0000, "R10");
    apply(3'd2, 4'b1011, 1'b0, 4'b0000, "R4");

    // R8: the mask is ignored while the strobe is low
    apply(3'd2, 4'b1011, 1'b0, 4'b1111, "R8");
    // R8: clear with the input still active, then recapture in level mode
    apply(3'd0, 4'b1111, 1'b1, 4'b1111, "R8");
    apply(3'd0, 4'b1111, 1'b0, 4'b0000, "R2");
    // R7: any-edge pulse on a toggling input
    apply(3'd7, 4'b0000, 1'b0, 4'b0000, "R7");
    apply(3'd7, 4'b0000, 1'b0, 4'b0000, "R7");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule